// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two 36-bit two's-complement words (one sign bit and 35 magnitude bits) over many clock cycles. It takes the magnitudes of both operands and builds their product one multiplier bit per cycle. At each step the multiplicand is added into a running sum only when the current multiplier bit is set. One final cycle applies the product sign. A single datapath serves two readings of the operands. In fractional mode both words are fixed-point values in (-1.0, 1.0), and the upper product word is the answer. In integer mode the operands are whole numbers, the lower product word is the answer, and a flag reports when the product does not fit in one word.

A caller raises `start` for one cycle while the block is idle. The operands and the mode are captured at that edge. `busy` stays high while the product is being formed, and `done` pulses for one cycle when the outputs are valid. Besides the single-word answer, the block always presents the whole product as a double word. That double word holds 70 magnitude bits, and its sign is repeated at the top of both words.

Top module: `shiftAddMul`

## Requirements
- R1: After reset `busy`, `done`, `overflow`, `result`, `prodHi` and `prodLo` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low captures `opA`, `opB` and `modeFrac`. `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle. That cycle begins 37 clock edges after the edge that captured `start`: 36 step cycles plus one sign cycle. `busy` is low in the cycle where `done` is high.
- R4: A `start` raised while `busy` is high has no effect on the operation in progress or on its outputs.
- R5: With P the true signed product taken to 71 bits, `prodHi` = P[70:35]. `prodLo` = {P[70], P[34:0]}, so the sign bit appears in bit 35 of both words.
- R6: Fractional mode (`modeFrac` = 1) gives `result` = `prodHi`. `overflow` is set only when both operands are 400000000000 octal (-1.0 times -1.0).
- R7: Integer mode (`modeFrac` = 0) gives `result` = P[35:0]. `overflow` is set exactly when the product lies outside [-2^35, 2^35-1], that is, when product bits 71..35 are not all equal.
- R8: Once `done` has pulsed, `result`, `overflow`, `prodHi` and `prodLo` hold their values until the next accepted `start`, even if the operand and mode inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; honoured only when idle |
| opA | input | 36 | Multiplicand, two's complement |
| opB | input | 36 | Multiplier, two's complement |
| modeFrac | input | 1 | 1 = fractional (upper word), 0 = integer (lower word) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, outputs valid |
| result | output | 36 | Single-word answer for the chosen mode |
| overflow | output | 1 | Product out of range for the chosen mode |
| prodHi | output | 36 | Upper word of the double-word product |
| prodLo | output | 36 | Lower word of the double-word product, sign repeated |

## Verification
The operand table pairs small integers of each sign combination with the extreme fixed-point values. This shows whether the magnitude-then-sign path negates correctly and whether each mode selects the right product half. The products 2^35 and -2^35 in integer mode sit on either side of the overflow limit, which separates a sign-aware range test from a simple test of the upper bits. The operand pair -1.0 times -1.0 is run in both modes to exercise the only fractional overflow. A zero operand and a product of 1 check that no stray sign is produced. Directed runs then insert a `start` while the block is busy, and change the inputs after `done` to confirm the outputs hold.

// File: rtl/mulPkg.sv
package mulPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, magnitudes and mode
    logic step;  // one conditional add and shift
    logic fix;   // apply product sign
  } mulStrobes_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_t;

  state_t           state;
  logic [CNT_W-1:0] stepCnt;
  logic             doneQ;

  always_comb begin
    strobes.load = (state == ST_IDLE) && start;
    strobes.step = (state == ST_RUN);
    strobes.fix  = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (state == ST_FIX);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) state <= ST_FIX;
          else stepCnt <= stepCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/mulPath.sv
module mulPath
  import mulPkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mulStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             modeFrac,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  localparam int PROD_W = 2 * WIDTH;

  logic [WIDTH-1:0]  mcandMag;
  logic [PROD_W-1:0] prod;
  logic              negQ;
  logic              modeQ;

  logic [WIDTH-1:0]  magA;
  logic [WIDTH-1:0]  magB;
  logic [WIDTH-1:0]  addend;
  logic [WIDTH:0]    partial;

  // magnitudes; the most negative word maps to 2^(WIDTH-1)
  assign magA = opA[WIDTH-1] ? (~opA + 1'b1) : opA;
  assign magB = opB[WIDTH-1] ? (~opB + 1'b1) : opB;

  assign addend  = prod[0] ? mcandMag : '0;
  assign partial = {1'b0, prod[PROD_W-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcandMag <= '0;
      prod     <= '0;
      negQ     <= 1'b0;
      modeQ    <= 1'b0;
    end else if (strobes.load) begin
      mcandMag <= magA;
      prod     <= {{WIDTH{1'b0}}, magB};
      negQ     <= opA[WIDTH-1] ^ opB[WIDTH-1];
      modeQ    <= modeFrac;
    end else if (strobes.step) begin
      prod <= {partial, prod[WIDTH-1:1]};
    end else if (strobes.fix) begin
      if (negQ) prod <= ~prod + PROD_W'(1);
    end
  end

  // double-word form: sign bit repeated at the top of the low word
  assign prodHi = prod[PROD_W-2:WIDTH-1];
  assign prodLo = {prod[PROD_W-2], prod[WIDTH-2:0]};

  logic fracOvf;
  logic intOvf;
  assign fracOvf = ~prod[PROD_W-1] & prod[PROD_W-2];
  assign intOvf  = !((&prod[PROD_W-1:WIDTH-1]) || (prod[PROD_W-1:WIDTH-1] == '0));

  assign result   = modeQ ? prodHi : prod[WIDTH-1:0];
  assign overflow = modeQ ? fracOvf : intOvf;
endmodule

// File: rtl/shiftAddMul.sv
module shiftAddMul
  import mulPkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             modeFrac,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  mulStrobes_t strobes;

  mulCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  mulPath #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .modeFrac (modeFrac),
    .result   (result),
    .overflow (overflow),
    .prodHi   (prodHi),
    .prodLo   (prodLo)
  );
endmodule

// File: rtl/mulChecker.sv
module mulChecker #(
  parameter int WIDTH = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             modeFrac,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic             overflow,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo
);
  int unsigned lat;
  logic        modeSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat      <= 0;
      modeSeen <= 1'b0;
    end else if (start && !busy) begin
      lat      <= 0;
      modeSeen <= modeFrac;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  p_busy_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == WIDTH + 1) && !busy);

  p_lo_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prodLo[WIDTH-1] == prodHi[WIDTH-1]));

  p_frac_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modeSeen) |-> (result == prodHi));

  p_int_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !modeSeen && !overflow) |-> (prodHi == {WIDTH{result[WIDTH-1]}}));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(overflow) &&
                           $stable(prodHi) && $stable(prodLo)));
endmodule

bind shiftAddMul mulChecker #(.WIDTH(WIDTH)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .modeFrac (modeFrac),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .overflow (overflow),
  .prodHi   (prodHi),
  .prodLo   (prodLo)
);

// File: tb/sim_shiftAddMul.sv
`timescale 1ns/1ps
module sim_shiftAddMul;
  localparam int W = 36;
  localparam int NV = 14;
  localparam logic [W-1:0] MINW = 36'o400000000000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         modeFrac = 1'b0;
  logic         busy, done, overflow;
  logic [W-1:0] result, prodHi, prodLo;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shiftAddMul #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .modeFrac(modeFrac), .busy(busy), .done(done), .result(result),
    .overflow(overflow), .prodHi(prodHi), .prodLo(prodLo)
  );

  localparam logic [W-1:0] VA [NV] = '{
    36'o3, 36'o777777777775, 36'o377777777777, 36'o377777777777,
    MINW, MINW, MINW, 36'o777777777777, 36'o0, 36'o200000000000,
    36'o400000, 36'o777777400000, 36'o400000000001, 36'o123456701234};
  localparam logic [W-1:0] VB [NV] = '{
    36'o5, 36'o5, 36'o377777777777, 36'o377777777777,
    MINW, MINW, 36'o1, 36'o777777777777, 36'o777777777777, 36'o200000000000,
    36'o1000000, 36'o1000000, 36'o377777777777, 36'o765432107654};
  localparam logic VM [NV] = '{
    1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // behavioural model of the full signed product
  function automatic logic [71:0] fullProd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [71:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                       input bit intrude, output int lat);
    @(negedge clk);
    opA = a; opB = b; modeFrac = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    check(busy === 1'b1, "R2 busy after start", 72'(busy), 72'd1);
    if (intrude) begin
      @(negedge clk); lat++;
      start = 1'b1; opA = ~a; opB = b ^ 36'o123; modeFrac = ~m;
      @(negedge clk); lat++;
      start = 1'b0;
    end
    while (!done && lat < 100) begin
      @(negedge clk); lat++;
    end
    check(busy === 1'b0, "R3 busy low with done", 72'(busy), 72'd0);
  endtask

  task automatic checkResult(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                             input string tag);
    logic [71:0] p;
    logic [W-1:0] eHi, eLo, eRes;
    logic eOvf;
    p = fullProd(a, b);
    eHi = p[70:35];
    eLo = {p[70], p[34:0]};
    if (m) begin
      eRes = eHi;
      eOvf = (a == MINW) && (b == MINW);
    end else begin
      eRes = p[35:0];
      eOvf = !((p[71:35] == '0) || (&p[71:35]));
    end
    check(prodHi === eHi, {tag, " R5 prodHi"}, 72'(prodHi), 72'(eHi));
    check(prodLo === eLo, {tag, " R5 prodLo"}, 72'(prodLo), 72'(eLo));
    check(result === eRes, {tag, m ? " R6 result" : " R7 result"}, 72'(result), 72'(eRes));
    check(overflow === eOvf, {tag, m ? " R6 overflow" : " R7 overflow"},
          72'(overflow), 72'(eOvf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lat;
    logic [W-1:0] holdRes, holdHi, holdLo;
    logic holdOvf;

    repeat (3) @(negedge clk);
    // R1: reset values
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {70'd0, busy, done}, 72'd0);
    check(result === '0 && overflow === 1'b0, "R1 result/overflow in reset",
          72'(result), 72'd0);
    check(prodHi === '0 && prodLo === '0, "R1 product words in reset", 72'(prodHi), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of operand pairs and modes
    for (int i = 0; i < NV; i++) begin
      runOp(VA[i], VB[i], VM[i], 1'b0, lat);
      check(lat - 1 == W + 1, "R3 done latency", 72'(lat - 1), 72'(W + 1));
      checkResult(VA[i], VB[i], VM[i], $sformatf("vec%0d", i));
      @(negedge clk);
      check(done === 1'b0, "R3 done one cycle", 72'(done), 72'd0);
    end

    // R4: start while busy is ignored
    runOp(36'o7, 36'o777777777771, 1'b0, 1'b1, lat);
    check(lat - 1 == W + 1, "R4 latency unchanged by start while busy", 72'(lat - 1), 72'(W + 1));
    checkResult(36'o7, 36'o777777777771, 1'b0, "R4 intrude");

    // R8: outputs hold after done while inputs move
    holdRes = result; holdHi = prodHi; holdLo = prodLo; holdOvf = overflow;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      opA = opA + 36'o1111; opB = ~opB; modeFrac = ~modeFrac;
    end
    check(result === holdRes, "R8 result held", 72'(result), 72'(holdRes));
    check(prodHi === holdHi && prodLo === holdLo, "R8 product words held",
          72'(prodHi), 72'(holdHi));
    check(overflow === holdOvf, "R8 overflow held", 72'(overflow), 72'(holdOvf));
    check(busy === 1'b0 && done === 1'b0, "R8 idle without start", {70'd0, busy, done}, 72'd0);

    // back-to-back: a new start is accepted right after done
    runOp(MINW, 36'o777777777777, 1'b0, 1'b0, lat);
    checkResult(MINW, 36'o777777777777, 1'b0, "R7 minword times -1");
    runOp(MINW, 36'o777777777777, 1'b1, 1'b0, lat);
    checkResult(MINW, 36'o777777777777, 1'b1, "R6 -1.0 times tiny negative");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule